// File: doc/BRIEF.md
# Batched Strided GEMM Address Sequencer

This controller drives a fixed-size matrix-multiply tile array through a batch of larger products. After a start pulse it holds a copy of the sizes and strides for the whole run. It then walks four block indices, with the batch index outermost, followed by the row block m, the column block n, and the depth block k innermost. For every step it presents the start addresses of the A, B and C sub-matrices. It also marks whether the tile should accumulate into C or begin a new sum, and it raises a write strobe when a C block is complete.

Each data-valid strobe that arrives while the sequencer is busy consumes the current step and moves to the next one. Addresses are formed by adding strides one step at a time instead of multiplying. A, B and C each have three strides: one for the innermost block step, one for the leading-dimension step and one for the batch step. When the last step of the last batch has been consumed, busy falls and a one-cycle done pulse follows.

Top module: `gemm_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, c_write and accumulate are all 0.
- R2: A start pulse seen while busy is 0 captures every configuration input. Busy is 1 from the next cycle, and in that cycle addr_a, addr_b and addr_c equal a_base, b_base and c_base.
- R3: The steps run in nested order batch, m, n, k, with k changing fastest. Each cycle in which busy and data_valid are both 1 consumes exactly one step. A busy cycle without data_valid changes no output.
- R4: While busy, addr_a = a_base + batch*a_step_batch + m*a_step_m + k*a_step_k, taken modulo 2^32.
- R5: While busy, addr_b = b_base + batch*b_step_batch + n*b_step_n + k*b_step_k, taken modulo 2^32.
- R6: While busy, addr_c = c_base + batch*c_step_batch + m*c_step_m + n*c_step_n, taken modulo 2^32. This value does not change while k sweeps.
- R7: accumulate is 0 when the current k is 0 and 1 when k is greater than 0.
- R8: c_write is 1 in exactly those cycles in which a step with k = cfg_k-1 is consumed. addr_c in that cycle gives the block being written. A run produces batch*m*n strobes.
- R9: The cycle after the final step is consumed, busy is 0 and done is 1. Done lasts exactly one cycle.
- R10: While busy is 1, start and all configuration inputs are ignored.
- R11: With all four sizes equal to 1, a run consumes exactly one step, raises c_write once with accumulate 0, and then finishes.
- R12: A size field of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; captured only while idle |
| data_valid | input | 1 | Consume the current step |
| cfg_batch | input | 8 | Number of batches |
| cfg_m | input | 8 | Row block count |
| cfg_n | input | 8 | Column block count |
| cfg_k | input | 8 | Depth block count |
| a_base | input | 32 | Start address of A |
| b_base | input | 32 | Start address of B |
| c_base | input | 32 | Start address of C |
| a_step_k | input | 32 | A increment per k block |
| a_step_m | input | 32 | A increment per m block |
| a_step_batch | input | 32 | A increment per batch |
| b_step_k | input | 32 | B increment per k block |
| b_step_n | input | 32 | B increment per n block |
| b_step_batch | input | 32 | B increment per batch |
| c_step_n | input | 32 | C increment per n block |
| c_step_m | input | 32 | C increment per m block |
| c_step_batch | input | 32 | C increment per batch |
| addr_a | output | 32 | Current A sub-matrix address |
| addr_b | output | 32 | Current B sub-matrix address |
| addr_c | output | 32 | Current C sub-matrix address |
| accumulate | output | 1 | Add into C (1) or start a new sum (0) |
| c_write | output | 1 | C block complete in this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is a carry through all four loop levels in the same cycle. At that carry the incremental walkers must reload two or three of their base registers together, and this has to happen while data_valid arrives in irregular bursts. The stimulus uses small, unequal sizes (for example 2, 3, 2, 3) so that every carry depth occurs several times within a short run. It uses unrelated random strides so that a reload from the wrong base shows up as a wrong address, and it gates data_valid at random so that consumption and stalls interleave. The bench also raises start with a different configuration in the middle of a run to confirm that it is ignored.

// File: rtl/gas_pkg.sv
package gas_pkg;
  // Address update events for one operand walker, one cycle each.
  typedef struct packed {
    logic ld;        // load all levels from the base pointer
    logic st_outer;  // batch step
    logic st_mid;    // middle block step
    logic rs_mid;    // middle level back to batch base
    logic st_inner;  // inner block step
    logic rs_inner;  // inner level back to middle base
  } walk_ev_t;

  localparam int unsigned NUM_LVL = 4;  // k, n, m, batch
  localparam int unsigned NUM_OPS = 3;  // A, B, C
endpackage

// File: rtl/gas_idx_ctr.sv
module gas_idx_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] idx_d;
  logic         idx_en;

  assign last = (idx == lim - 1'b1);

  always_comb begin
    idx_en = clr | inc;
    idx_d  = idx;
    if (clr)       idx_d = '0;
    else if (inc)  idx_d = last ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end
endmodule

// File: rtl/gas_addr_walk.sv
module gas_addr_walk
  import gas_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  walk_ev_t      ev,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] s_outer,
  input  logic [AW-1:0] s_mid,
  input  logic [AW-1:0] s_inner,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] outer_q, mid_q, outer_d, mid_d, addr_d;
  logic          en;

  always_comb begin
    outer_d = outer_q;
    mid_d   = mid_q;
    addr_d  = addr;
    en      = ev.ld | ev.st_outer | ev.st_mid | ev.rs_mid | ev.st_inner | ev.rs_inner;
    if (ev.ld) begin
      outer_d = ptr;
      mid_d   = ptr;
      addr_d  = ptr;
    end else if (ev.st_outer) begin
      outer_d = outer_q + s_outer;
      mid_d   = outer_q + s_outer;
      addr_d  = outer_q + s_outer;
    end else if (ev.st_mid) begin
      mid_d  = mid_q + s_mid;
      addr_d = mid_q + s_mid;
    end else if (ev.rs_mid) begin
      mid_d  = outer_q;
      addr_d = outer_q;
    end else if (ev.rs_inner) begin
      addr_d = mid_q;
    end else if (ev.st_inner) begin
      addr_d = addr + s_inner;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outer_q <= '0;
      mid_q   <= '0;
      addr    <= '0;
    end else if (en) begin
      outer_q <= outer_d;
      mid_q   <= mid_d;
      addr    <= addr_d;
    end
  end
endmodule

// File: rtl/gemm_addr_seq.sv
module gemm_addr_seq
  import gas_pkg::*;
#(
  parameter int unsigned SW = 8,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          data_valid,
  input  logic [SW-1:0] cfg_batch,
  input  logic [SW-1:0] cfg_m,
  input  logic [SW-1:0] cfg_n,
  input  logic [SW-1:0] cfg_k,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  input  logic [AW-1:0] c_base,
  input  logic [AW-1:0] a_step_k,
  input  logic [AW-1:0] a_step_m,
  input  logic [AW-1:0] a_step_batch,
  input  logic [AW-1:0] b_step_k,
  input  logic [AW-1:0] b_step_n,
  input  logic [AW-1:0] b_step_batch,
  input  logic [AW-1:0] c_step_n,
  input  logic [AW-1:0] c_step_m,
  input  logic [AW-1:0] c_step_batch,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [AW-1:0] addr_c,
  output logic          accumulate,
  output logic          c_write,
  output logic          busy,
  output logic          done
);
  // Level 0 = k (innermost), 1 = n, 2 = m, 3 = batch.
  localparam int unsigned LV = NUM_LVL;
  localparam int unsigned OP = NUM_OPS;

  logic              accept, fire, finish;
  logic [SW-1:0]     size_in [LV];
  logic [SW-1:0]     lim_q   [LV];
  logic [SW-1:0]     idx     [LV];
  logic [LV-1:0]     last;
  logic [LV:0]       carry;
  logic [LV-1:0]     adv;
  logic [AW-1:0]     ptr_in  [OP];
  logic [AW-1:0]     str_in  [OP][3];  // [op][outer, mid, inner]
  logic [AW-1:0]     str_q   [OP][3];
  logic [AW-1:0]     addr_w  [OP];
  walk_ev_t          ev      [OP];
  logic              busy_d, done_d;

  assign accept = start & ~busy;
  assign fire   = busy & data_valid;

  assign size_in[0] = cfg_k;
  assign size_in[1] = cfg_n;
  assign size_in[2] = cfg_m;
  assign size_in[3] = cfg_batch;

  assign ptr_in[0] = a_base;
  assign ptr_in[1] = b_base;
  assign ptr_in[2] = c_base;
  assign str_in[0][0] = a_step_batch;
  assign str_in[0][1] = a_step_m;
  assign str_in[0][2] = a_step_k;
  assign str_in[1][0] = b_step_batch;
  assign str_in[1][1] = b_step_n;
  assign str_in[1][2] = b_step_k;
  assign str_in[2][0] = c_step_batch;
  assign str_in[2][1] = c_step_m;
  assign str_in[2][2] = c_step_n;

  // Loop counters with ripple carry, one per level.
  assign carry[0] = fire;
  for (genvar l = 0; l < LV; l++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lim_q[l] <= '0;
      else if (accept) lim_q[l] <= (size_in[l] == '0) ? SW'(1) : size_in[l];
    end

    gas_idx_ctr #(.W(SW)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (accept),
      .inc  (carry[l]),
      .lim  (lim_q[l]),
      .idx  (idx[l]),
      .last (last[l])
    );

    assign carry[l+1] = carry[l] & last[l];
    assign adv[l]     = carry[l] & ~last[l];
  end
  assign finish = carry[LV];

  // Per-operand event mapping onto the generic three-level walker.
  always_comb begin
    for (int o = 0; o < OP; o++) begin
      ev[o]          = '0;
      ev[o].ld       = accept;
      ev[o].st_outer = adv[3];
    end
    ev[0].st_mid   = adv[2];
    ev[0].rs_inner = adv[1];
    ev[0].st_inner = adv[0];
    ev[1].st_mid   = adv[1];
    ev[1].rs_mid   = adv[2];
    ev[1].st_inner = adv[0];
    ev[2].st_mid   = adv[2];
    ev[2].st_inner = adv[1];
  end

  for (genvar o = 0; o < OP; o++) begin : g_op
    for (genvar s = 0; s < 3; s++) begin : g_str
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      str_q[o][s] <= '0;
        else if (accept) str_q[o][s] <= str_in[o][s];
      end
    end

    gas_addr_walk #(.AW(AW)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev[o]),
      .ptr    (ptr_in[o]),
      .s_outer(str_q[o][0]),
      .s_mid  (str_q[o][1]),
      .s_inner(str_q[o][2]),
      .addr   (addr_w[o])
    );
  end

  assign addr_a     = addr_w[0];
  assign addr_b     = addr_w[1];
  assign addr_c     = addr_w[2];
  assign accumulate = (idx[0] != '0);
  assign c_write    = carry[1];

  always_comb begin
    busy_d = busy;
    if (accept)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= busy_d;
      done <= done_d;
    end
  end
endmodule

// File: rtl/gas_seq_chk.sv
module gas_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          data_valid,
  input logic [AW-1:0] addr_a,
  input logic [AW-1:0] addr_b,
  input logic [AW-1:0] addr_c,
  input logic          accumulate,
  input logic          c_write,
  input logic          busy,
  input logic          done
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_cwrite_gate: assert property (@(posedge clk) disable iff (!rst_n)
    c_write |-> (busy && data_valid));
  a_r6_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_valid && !c_write) |=> $stable(addr_c));
  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !data_valid) |=> ($stable(addr_a) && $stable(addr_b) &&
                               $stable(addr_c) && $stable(accumulate) && busy));
  a_r7_first_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !accumulate);
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !data_valid) |=> (busy && $stable(addr_a)));
endmodule

bind gemm_addr_seq gas_seq_chk #(.AW(AW)) u_gas_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .data_valid(data_valid),
  .addr_a    (addr_a),
  .addr_b    (addr_b),
  .addr_c    (addr_c),
  .accumulate(accumulate),
  .c_write   (c_write),
  .busy      (busy),
  .done      (done)
);

// File: tb/tb_gemm_addr_seq.sv
module tb_gemm_addr_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, data_valid = 1'b0;
  logic [7:0]  cfg_batch = '0, cfg_m = '0, cfg_n = '0, cfg_k = '0;
  logic [31:0] a_base = '0, b_base = '0, c_base = '0;
  logic [31:0] a_step_k = '0, a_step_m = '0, a_step_batch = '0;
  logic [31:0] b_step_k = '0, b_step_n = '0, b_step_batch = '0;
  logic [31:0] c_step_n = '0, c_step_m = '0, c_step_batch = '0;
  logic [31:0] addr_a, addr_b, addr_c;
  logic accumulate, c_write, busy, done;

  gemm_addr_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cycles = 0, cw_cnt = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          mbusy, mdone;
  int          lb, lm, ln, lk, ib, im, in_, ik;
  logic [31:0] pa, pb, pc, sak, sam, sab, sbk, sbn, sbb, scn, scm, scb;

  function automatic int clamp1(logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy = 0; mdone = 0; ib = 0; im = 0; in_ = 0; ik = 0;
      lb = 1; lm = 1; ln = 1; lk = 1;
    end else begin
      mdone = 0;
      if (!mbusy && start) begin
        lb = clamp1(cfg_batch); lm = clamp1(cfg_m);
        ln = clamp1(cfg_n);     lk = clamp1(cfg_k);
        pa = a_base; pb = b_base; pc = c_base;
        sak = a_step_k; sam = a_step_m; sab = a_step_batch;
        sbk = b_step_k; sbn = b_step_n; sbb = b_step_batch;
        scn = c_step_n; scm = c_step_m; scb = c_step_batch;
        ib = 0; im = 0; in_ = 0; ik = 0; mbusy = 1;
      end else if (mbusy && data_valid) begin
        if (ik < lk-1) ik++;
        else begin
          ik = 0;
          if (in_ < ln-1) in_++;
          else begin
            in_ = 0;
            if (im < lm-1) im++;
            else begin
              im = 0;
              if (ib < lb-1) ib++;
              else begin ib = 0; mbusy = 0; mdone = 1; end
            end
          end
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (c_write === 1'b1) cw_cnt++;
      chk("R3 busy", 32'(busy), 32'(mbusy));
      chk("R9 done", 32'(done), 32'(mdone));
      chk("R8 c_write", 32'(c_write), 32'(mbusy && data_valid && ik == lk-1));
      if (mbusy) begin
        chk("R7 accumulate", 32'(accumulate), 32'(ik != 0));
        chk("R4 addr_a", addr_a, pa + 32'(ib)*sab + 32'(im)*sam + 32'(ik)*sak);
        chk("R5 addr_b", addr_b, pb + 32'(ib)*sbb + 32'(in_)*sbn + 32'(ik)*sbk);
        chk("R6 addr_c", addr_c, pc + 32'(ib)*scb + 32'(im)*scm + 32'(in_)*scn);
      end
    end
  end

  task automatic set_cfg(int b, int m, int n, int k);
    cfg_batch = 8'(b); cfg_m = 8'(m); cfg_n = 8'(n); cfg_k = 8'(k);
    a_base = $urandom; b_base = $urandom; c_base = $urandom;
    a_step_k = $urandom; a_step_m = $urandom; a_step_batch = $urandom;
    b_step_k = $urandom; b_step_n = $urandom; b_step_batch = $urandom;
    c_step_n = $urandom; c_step_m = $urandom; c_step_batch = $urandom;
  endtask

  task automatic run(string tag, int b, int m, int n, int k, int dv_pct, bit poke);
    logic [31:0] ea, eb, ec;
    int exp_cw;
    exp_cw = clamp1(8'(b)) * clamp1(8'(m)) * clamp1(8'(n));
    @(posedge clk); #1;
    set_cfg(b, m, n, k);
    ea = a_base; eb = b_base; ec = c_base;
    start = 1'b1; data_valid = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    cw_cnt = 0;
    @(negedge clk);
    chk({tag, " R2 busy"}, 32'(busy), 32'd1);
    chk({tag, " R2 addr_a"}, addr_a, ea);
    chk({tag, " R2 addr_b"}, addr_b, eb);
    chk({tag, " R2 addr_c"}, addr_c, ec);
    for (int i = 0; mbusy && i < 5000; i++) begin
      @(posedge clk); #1;
      data_valid = (($urandom % 100) < dv_pct);
      if (poke && i == 3) begin
        set_cfg(7, 7, 7, 7);   // R10: ignored while busy
        start = 1'b1;
      end else start = 1'b0;
    end
    @(posedge clk); #1;
    data_valid = 1'b0; start = 1'b0;
    @(negedge clk);
    chk({tag, " R8 c_write count"}, 32'(cw_cnt), 32'(exp_cw));
    chk({tag, " R9 idle after run"}, 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 c_write", 32'(c_write), 32'd0);
    chk("R1 accumulate", 32'(accumulate), 32'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", 32'(busy), 32'd0);

    run("R11", 1, 1, 1, 1, 100, 0);
    run("R12", 0, 0, 0, 0, 60, 0);
    run("R12b", 1, 2, 0, 3, 70, 0);
    run("R3", 2, 3, 2, 3, 50, 0);
    run("R10", 2, 2, 3, 2, 60, 1);
    run("R4", 3, 1, 2, 4, 100, 0);
    run("R5", 2, 2, 2, 1, 30, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule